// File: doc/BRIEF.md
# Neighbour Core Mailbox Ring

This block links sixteen processor cores in a ring. Every core owns two single-entry mailboxes of its own, one aimed at the core above it and one at the core below it. A core can therefore pass a short word to either neighbour, and take one from either neighbour, without going through the shared-memory arbiter. Each mailbox holds a data register and a pending flag. A post sets the flag and a fetch clears it.

Each core has a post port and a fetch port. Both ports carry a direction bit that picks the lower (previous) or upper (next) neighbour, plus option bits. On the post side, a guard option refuses to overwrite a word that has not yet been collected and reports the refusal as carry. A strip option clears the command bit, bit 8, of the stored word. On the fetch side, a carry option returns the pending flag as it stood before the fetch. A strip option clears bit 8 of the returned word and returns the original bit in zero. All results are registered and appear one clock after the request.

Top module: `nbr_mailbox_ring`

## Requirements
- R1: Synchronous active-high reset clears every data register and pending flag, and sets every registered output (fetched data, carry, zero, post carry) to 0.
- R2: A post stores its word into the selected mailbox and sets that mailbox's pending flag. A fetch issued in a later cycle returns the word.
- R3: A guarded post (wr_cond=1) to a mailbox whose flag is set leaves the word unchanged and drives wr_carry=1 one cycle later. A guarded post to an empty mailbox stores the word and drives wr_carry=0. An unguarded post drives wr_carry=0.
- R4: An unguarded post always stores its word and sets the flag, even when the flag was already set.
- R5: With wr_mask=1, bit 8 of the stored word is 0 whatever bit 8 of wr_data is.
- R6: A fetch returns the mailbox contents and clears its flag. With rd_carry_en=1, rd_carry gives the flag value just before the fetch. With rd_carry_en=0, rd_carry is 0.
- R7: With rd_mask=1, the returned bit 8 is 0 and rd_zero carries the stored bit 8. With rd_mask=0, rd_zero is 0.
- R8: Direction bit 0 selects the previous core (index-1) and 1 selects the next core (index+1). A post by core c with direction 1 is seen by core c+1 fetching with direction 0, and a post with direction 0 is seen by core c-1 fetching with direction 1.
- R9: Core indices wrap modulo the core count, so core 15's next neighbour is core 0 and core 0's previous neighbour is core 15.
- R10: When a post and a fetch hit the same mailbox in the same cycle, the fetch returns the old word, the new word is stored, and the flag ends up set.
- R11: While a core's rd_en is low, its rd_data, rd_carry and rd_zero hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | N_CORES | Post request per core |
| wr_dir | input | N_CORES | Post direction per core (0 previous, 1 next) |
| wr_cond | input | N_CORES | Guarded post option per core |
| wr_mask | input | N_CORES | Clear bit 8 of the posted word |
| wr_data | input | N_CORES*DW | Posted word, core c at bits c*DW +: DW |
| rd_en | input | N_CORES | Fetch request per core |
| rd_dir | input | N_CORES | Fetch direction per core (0 previous, 1 next) |
| rd_carry_en | input | N_CORES | Return prior pending flag in carry |
| rd_mask | input | N_CORES | Strip bit 8 into zero |
| rd_data | output | N_CORES*DW | Fetched word per core, registered |
| rd_carry | output | N_CORES | Fetch carry per core, registered |
| rd_zero | output | N_CORES | Fetch zero per core, registered |
| wr_carry | output | N_CORES | Post refused flag per core, registered |

## Verification
Every result of this block is due exactly one clock edge after the request: fetched data, fetch carry and zero, and the refusal carry of a guarded post. A mailbox flag changed at edge k affects a fetch presented in the cycle after k. Each vector is therefore driven just after a falling edge and checked at the next falling edge, which lies half a period after the single edge that registers the result. Inputs return to idle before the next vector, so the bench can also check that outputs hold while nothing is fetched.

// File: rtl/nmr_pkg.sv
package nmr_pkg;
  typedef enum logic {
    DIR_PREV = 1'b0,
    DIR_NEXT = 1'b1
  } nmr_dir_e;

  function automatic int ring_next(input int idx, input int n);
    return (idx + 1) % n;
  endfunction

  function automatic int ring_prev(input int idx, input int n);
    return (idx + n - 1) % n;
  endfunction
endpackage

// File: rtl/nmr_mailbox.sv
module nmr_mailbox #(
  parameter int DW      = 9,
  parameter int CMD_BIT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          wr_cond,
  input  logic          wr_mask,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic [DW-1:0] data_q,
  output logic          avail_q
);
  localparam logic [DW-1:0] CMD_ONEHOT = {{(DW-1){1'b0}}, 1'b1} << CMD_BIT;

  logic          accept;
  logic [DW-1:0] store_val;

  // A guarded post is refused while the previous word is still pending.
  assign accept    = wr_req & ~(wr_cond & avail_q);
  assign store_val = wr_mask ? (wr_data & ~CMD_ONEHOT) : wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      avail_q <= 1'b0;
    end else begin
      if (accept) data_q <= store_val;
      // Posting wins over a same-cycle fetch, so the new word stays pending.
      if (accept)      avail_q <= 1'b1;
      else if (rd_req) avail_q <= 1'b0;
    end
  end
endmodule

// File: rtl/nmr_write_port.sv
module nmr_write_port (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic dir,
  input  logic cond,
  input  logic avail_dn,
  input  logic avail_up,
  output logic req_dn,
  output logic req_up,
  output logic carry_q
);
  import nmr_pkg::*;

  logic sel_avail;

  assign req_up    = en & (dir == DIR_NEXT);
  assign req_dn    = en & (dir == DIR_PREV);
  assign sel_avail = (dir == DIR_NEXT) ? avail_up : avail_dn;

  always_ff @(posedge clk) begin
    if (rst) carry_q <= 1'b0;
    else     carry_q <= en & cond & sel_avail;
  end
endmodule

// File: rtl/nmr_read_port.sv
module nmr_read_port #(
  parameter int DW      = 9,
  parameter int CMD_BIT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          dir,
  input  logic          carry_opt,
  input  logic          mask_opt,
  input  logic [DW-1:0] prev_data,
  input  logic          prev_avail,
  input  logic [DW-1:0] next_data,
  input  logic          next_avail,
  output logic          clr_prev,
  output logic          clr_next,
  output logic [DW-1:0] data_q,
  output logic          carry_q,
  output logic          zero_q
);
  import nmr_pkg::*;

  localparam logic [DW-1:0] CMD_ONEHOT = {{(DW-1){1'b0}}, 1'b1} << CMD_BIT;

  logic [DW-1:0] sel_data;
  logic          sel_avail;

  assign clr_prev  = en & (dir == DIR_PREV);
  assign clr_next  = en & (dir == DIR_NEXT);
  assign sel_data  = (dir == DIR_NEXT) ? next_data  : prev_data;
  assign sel_avail = (dir == DIR_NEXT) ? next_avail : prev_avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (en) begin
      data_q  <= mask_opt ? (sel_data & ~CMD_ONEHOT) : sel_data;
      carry_q <= carry_opt & sel_avail;
      zero_q  <= mask_opt & sel_data[CMD_BIT];
    end
  end
endmodule

// File: rtl/nbr_mailbox_ring.sv
module nbr_mailbox_ring #(
  parameter int N_CORES = 16,
  parameter int DW      = 9,
  parameter int CMD_BIT = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_CORES-1:0]    wr_en,
  input  logic [N_CORES-1:0]    wr_dir,
  input  logic [N_CORES-1:0]    wr_cond,
  input  logic [N_CORES-1:0]    wr_mask,
  input  logic [N_CORES*DW-1:0] wr_data,
  input  logic [N_CORES-1:0]    rd_en,
  input  logic [N_CORES-1:0]    rd_dir,
  input  logic [N_CORES-1:0]    rd_carry_en,
  input  logic [N_CORES-1:0]    rd_mask,
  output logic [N_CORES*DW-1:0] rd_data,
  output logic [N_CORES-1:0]    rd_carry,
  output logic [N_CORES-1:0]    rd_zero,
  output logic [N_CORES-1:0]    wr_carry
);
  import nmr_pkg::*;

  // up box c carries core c -> core c+1, dn box c carries core c -> core c-1
  logic [DW-1:0]      up_data [N_CORES];
  logic [DW-1:0]      dn_data [N_CORES];
  logic [N_CORES-1:0] up_avail_v;
  logic [N_CORES-1:0] dn_avail_v;
  logic [N_CORES-1:0] up_wr_req;
  logic [N_CORES-1:0] dn_wr_req;
  logic [N_CORES-1:0] rd_clr_prev;
  logic [N_CORES-1:0] rd_clr_next;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    localparam int NXT = ring_next(c, N_CORES);
    localparam int PRV = ring_prev(c, N_CORES);

    nmr_mailbox #(.DW(DW), .CMD_BIT(CMD_BIT)) up_box_i (
      .clk     (clk),
      .rst     (rst),
      .wr_req  (up_wr_req[c]),
      .wr_cond (wr_cond[c]),
      .wr_mask (wr_mask[c]),
      .wr_data (wr_data[c*DW +: DW]),
      .rd_req  (rd_clr_prev[NXT]),
      .data_q  (up_data[c]),
      .avail_q (up_avail_v[c])
    );

    nmr_mailbox #(.DW(DW), .CMD_BIT(CMD_BIT)) dn_box_i (
      .clk     (clk),
      .rst     (rst),
      .wr_req  (dn_wr_req[c]),
      .wr_cond (wr_cond[c]),
      .wr_mask (wr_mask[c]),
      .wr_data (wr_data[c*DW +: DW]),
      .rd_req  (rd_clr_next[PRV]),
      .data_q  (dn_data[c]),
      .avail_q (dn_avail_v[c])
    );

    nmr_write_port wr_port_i (
      .clk      (clk),
      .rst      (rst),
      .en       (wr_en[c]),
      .dir      (wr_dir[c]),
      .cond     (wr_cond[c]),
      .avail_dn (dn_avail_v[c]),
      .avail_up (up_avail_v[c]),
      .req_dn   (dn_wr_req[c]),
      .req_up   (up_wr_req[c]),
      .carry_q  (wr_carry[c])
    );

    nmr_read_port #(.DW(DW), .CMD_BIT(CMD_BIT)) rd_port_i (
      .clk        (clk),
      .rst        (rst),
      .en         (rd_en[c]),
      .dir        (rd_dir[c]),
      .carry_opt  (rd_carry_en[c]),
      .mask_opt   (rd_mask[c]),
      .prev_data  (up_data[PRV]),
      .prev_avail (up_avail_v[PRV]),
      .next_data  (dn_data[NXT]),
      .next_avail (dn_avail_v[NXT]),
      .clr_prev   (rd_clr_prev[c]),
      .clr_next   (rd_clr_next[c]),
      .data_q     (rd_data[c*DW +: DW]),
      .carry_q    (rd_carry[c]),
      .zero_q     (rd_zero[c])
    );
  end
endmodule

// File: rtl/nmr_ring_checker.sv
module nmr_ring_checker #(
  parameter int N_CORES = 16,
  parameter int DW      = 9,
  parameter int CMD_BIT = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [N_CORES-1:0]    wr_en,
  input logic [N_CORES-1:0]    wr_dir,
  input logic [N_CORES-1:0]    wr_cond,
  input logic [N_CORES-1:0]    rd_en,
  input logic [N_CORES-1:0]    rd_dir,
  input logic [N_CORES-1:0]    rd_mask,
  input logic [N_CORES*DW-1:0] rd_data,
  input logic [N_CORES-1:0]    wr_carry,
  input logic [N_CORES-1:0]    up_avail,
  input logic [N_CORES-1:0]    dn_avail
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (up_avail == '0) && (dn_avail == '0) && (wr_carry == '0));

  for (genvar c = 0; c < N_CORES; c++) begin : g_chk
    localparam int NXT = (c + 1) % N_CORES;

    assert_post_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
      wr_en[c] && wr_dir[c] && !wr_cond[c] |=> up_avail[c]);

    assert_idle_flag_stable_R2: assert property (@(posedge clk) disable iff (rst)
      !(wr_en[c] && wr_dir[c]) && !(rd_en[NXT] && !rd_dir[NXT]) |=> $stable(up_avail[c]));

    assert_refusal_reported_R3: assert property (@(posedge clk) disable iff (rst)
      wr_en[c] && wr_dir[c] && wr_cond[c] && up_avail[c] |=> wr_carry[c]);

    assert_fetch_clears_flag_R6: assert property (@(posedge clk) disable iff (rst)
      rd_en[NXT] && !rd_dir[NXT] && !(wr_en[c] && wr_dir[c]) |=> !up_avail[c]);

    assert_strip_cmd_bit_R7: assert property (@(posedge clk) disable iff (rst)
      rd_en[c] && rd_mask[c] |=> !rd_data[c*DW + CMD_BIT]);

    assert_output_hold_R11: assert property (@(posedge clk) disable iff (rst)
      !rd_en[c] |=> $stable(rd_data[c*DW +: DW]));
  end
endmodule

bind nbr_mailbox_ring nmr_ring_checker #(
  .N_CORES (N_CORES),
  .DW      (DW),
  .CMD_BIT (CMD_BIT)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_dir   (wr_dir),
  .wr_cond  (wr_cond),
  .rd_en    (rd_en),
  .rd_dir   (rd_dir),
  .rd_mask  (rd_mask),
  .rd_data  (rd_data),
  .wr_carry (wr_carry),
  .up_avail (up_avail_v),
  .dn_avail (dn_avail_v)
);

// File: tb/nbr_mailbox_ring_tb.sv
module nbr_mailbox_ring_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int DW = 9;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    wr_en, wr_dir, wr_cond, wr_mask;
  logic [N*DW-1:0] wr_data;
  logic [N-1:0]    rd_en, rd_dir, rd_carry_en, rd_mask;
  logic [N*DW-1:0] rd_data;
  logic [N-1:0]    rd_carry, rd_zero, wr_carry;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nbr_mailbox_ring #(.N_CORES(N), .DW(DW), .CMD_BIT(8)) dut_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_dir(wr_dir), .wr_cond(wr_cond), .wr_mask(wr_mask),
    .wr_data(wr_data),
    .rd_en(rd_en), .rd_dir(rd_dir), .rd_carry_en(rd_carry_en), .rd_mask(rd_mask),
    .rd_data(rd_data), .rd_carry(rd_carry), .rd_zero(rd_zero), .wr_carry(wr_carry)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [3:0] wc;
    logic       wen, wdir, wcond, wmask;
    logic [8:0] wd;
    logic [3:0] rc;
    logic       ren, rdir, rcy, rmsk;
    logic [8:0] ed;
    logic       ec, ez, ewc;
  } vec_t;

  localparam int NV = 15;
  // req, wcore, wen, wdir, wcond, wmask, wdata, rcore, ren, rdir, rcarry, rmask, exp data, exp c, exp z, exp wcarry
  localparam vec_t VECS [NV] = '{
    '{4'd2,  4'd0,  1'b1,1'b1,1'b0,1'b0, 9'h0A5, 4'd0,  1'b0,1'b0,1'b0,1'b0, 9'h000, 1'b0,1'b0,1'b0}, // R2 post up
    '{4'd6,  4'd0,  1'b0,1'b0,1'b0,1'b0, 9'h000, 4'd1,  1'b1,1'b0,1'b1,1'b0, 9'h0A5, 1'b1,1'b0,1'b0}, // R6 fetch, flag was set
    '{4'd6,  4'd0,  1'b0,1'b0,1'b0,1'b0, 9'h000, 4'd1,  1'b1,1'b0,1'b1,1'b0, 9'h0A5, 1'b0,1'b0,1'b0}, // R6 flag now clear
    '{4'd5,  4'd3,  1'b1,1'b0,1'b0,1'b1, 9'h1FF, 4'd0,  1'b0,1'b0,1'b0,1'b0, 9'h000, 1'b0,1'b0,1'b0}, // R5 masked post down
    '{4'd5,  4'd0,  1'b0,1'b0,1'b0,1'b0, 9'h000, 4'd2,  1'b1,1'b1,1'b1,1'b1, 9'h0FF, 1'b1,1'b0,1'b0}, // R5 bit 8 stored as 0
    '{4'd3,  4'd5,  1'b1,1'b1,1'b0,1'b0, 9'h134, 4'd0,  1'b0,1'b0,1'b0,1'b0, 9'h000, 1'b0,1'b0,1'b0}, // R3 fill
    '{4'd3,  4'd5,  1'b1,1'b1,1'b1,1'b0, 9'h055, 4'd0,  1'b0,1'b0,1'b0,1'b0, 9'h000, 1'b0,1'b0,1'b1}, // R3 guarded refused
    '{4'd7,  4'd0,  1'b0,1'b0,1'b0,1'b0, 9'h000, 4'd6,  1'b1,1'b0,1'b1,1'b1, 9'h034, 1'b1,1'b1,1'b0}, // R7 strip into zero
    '{4'd3,  4'd5,  1'b1,1'b1,1'b1,1'b0, 9'h055, 4'd0,  1'b0,1'b0,1'b0,1'b0, 9'h000, 1'b0,1'b0,1'b0}, // R3 guarded accepted
    '{4'd10, 4'd5,  1'b1,1'b1,1'b0,1'b0, 9'h066, 4'd6,  1'b1,1'b0,1'b0,1'b0, 9'h055, 1'b0,1'b0,1'b0}, // R10 collide, R6 no carry opt
    '{4'd4,  4'd0,  1'b0,1'b0,1'b0,1'b0, 9'h000, 4'd6,  1'b1,1'b0,1'b1,1'b0, 9'h066, 1'b1,1'b0,1'b0}, // R4 overwrite, R10 flag set
    '{4'd9,  4'd15, 1'b1,1'b1,1'b0,1'b0, 9'h1C3, 4'd0,  1'b0,1'b0,1'b0,1'b0, 9'h000, 1'b0,1'b0,1'b0}, // R9 wrap up
    '{4'd9,  4'd0,  1'b0,1'b0,1'b0,1'b0, 9'h000, 4'd0,  1'b1,1'b0,1'b1,1'b0, 9'h1C3, 1'b1,1'b0,1'b0}, // R9 core 0 from 15
    '{4'd8,  4'd0,  1'b1,1'b0,1'b0,1'b0, 9'h017, 4'd15, 1'b1,1'b1,1'b1,1'b0, 9'h000, 1'b0,1'b0,1'b0}, // R8 same cycle, box was empty
    '{4'd8,  4'd0,  1'b0,1'b0,1'b0,1'b0, 9'h000, 4'd15, 1'b1,1'b1,1'b1,1'b0, 9'h017, 1'b1,1'b0,1'b0}  // R8 down path
  };

  task automatic check(input int req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = '0; wr_dir = '0; wr_cond = '0; wr_mask = '0; wr_data = '0;
    rd_en = '0; rd_dir = '0; rd_carry_en = '0; rd_mask = '0;
  endtask

  task automatic drive(input vec_t v);
    int w, r;
    w = int'(v.wc);
    r = int'(v.rc);
    idle();
    wr_en[w] = v.wen; wr_dir[w] = v.wdir; wr_cond[w] = v.wcond; wr_mask[w] = v.wmask;
    wr_data[w*DW +: DW] = v.wd;
    rd_en[r] = v.ren; rd_dir[r] = v.rdir; rd_carry_en[r] = v.rcy; rd_mask[r] = v.rmsk;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(1, "rd_data after reset", int'(rd_data != '0), 0);
    check(1, "rd_carry after reset", int'(rd_carry), 0);
    check(1, "rd_zero after reset", int'(rd_zero), 0);
    check(1, "wr_carry after reset", int'(wr_carry), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v);
      step();
      if (v.ren) begin
        check(int'(v.req), $sformatf("vec %0d rd_data", i), int'(rd_data[int'(v.rc)*DW +: DW]), int'(v.ed));
        check(int'(v.req), $sformatf("vec %0d rd_carry", i), int'(rd_carry[v.rc]), int'(v.ec));
        check(int'(v.req), $sformatf("vec %0d rd_zero", i), int'(rd_zero[v.rc]), int'(v.ez));
      end
      if (v.wen)
        check(int'(v.req), $sformatf("vec %0d wr_carry", i), int'(wr_carry[v.wc]), int'(v.ewc));
    end

    // R11 outputs hold across idle cycles
    step();
    step();
    check(11, "core15 held data", int'(rd_data[15*DW +: DW]), 'h017);
    check(11, "core15 held carry", int'(rd_carry[15]), 1);
    check(11, "core1 held data", int'(rd_data[1*DW +: DW]), 'h0A5);
    check(11, "core6 held data", int'(rd_data[6*DW +: DW]), 'h066);

    // R1 reset in mid-run drops a pending word
    wr_en[9] = 1'b1; wr_dir[9] = 1'b1; wr_data[9*DW +: DW] = 9'h0C7;
    step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    check(1, "outputs cleared by reset", int'(rd_data != '0), 0);
    rd_en[10] = 1'b1; rd_carry_en[10] = 1'b1;
    step();
    check(1, "flag cleared by reset", int'(rd_carry[10]), 0);
    check(1, "data cleared by reset", int'(rd_data[10*DW +: DW]), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule